// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt request lines from the peripherals of a chip and turns them into one prioritised request for the processor. On every rising clock edge each request line is captured into a sticky pending flag. The flag is then gated by a per-source enable bit. Several sources can fold onto the same vector number. The block picks the winning vector, the one with the highest programmed level. It presents that vector's number, its level and a shadow register set number to the core from registers.

Software reaches the block through a flat word-addressed register port. Flags are cleared by writing ones. Enables, the per-vector levels and a control word are read/write. A read-only status word mirrors the presented vector and level.

The control word selects one of two modes. In single-vector mode, every winning interrupt reports one programmable shadow set. In multi-vector mode, level-7 interrupts report a dedicated shadow set and all others report set 0. The block leaves reset in single-vector mode.

Top module: `intc_vpic`

## Requirements
- R1: A request line high at a rising clock edge sets its source's flag at that edge. The flag stays set when the line drops. Flags read back at address 0x00+k, where bit b is source 32k+b.
- R2: A write to a flag word clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged. If a request arrives in the same cycle as the clear, the flag stays set.
- R3: A flag whose enable bit is 0 takes no part in arbitration. When no enabled flag is pending, the presented level is 0.
- R4: Source s belongs to vector s mod NUM_VEC. With the defaults, sources 64 to 95 share vectors 0 to 31.
- R5: Each vector has a 3-bit level at address 0x10+v/8, in bits 4*(v%8)+2 to 4*(v%8). A vector at level 0 never wins. With no winner, the outputs present vector 0, level 0 and set 0.
- R6: The winner is the pending vector with the highest level. On equal levels, the lower vector number wins.
- R7: The control word at 0x20 holds the mode in bit 0 (0 = single, 1 = multi) and the single-mode shadow set in bits 11:8. In multi mode, a level-7 winner reports set DED_SRS (default 1) and any other winner reports set 0. In single mode, any winner reports the programmed set.
- R8: The status word at 0x21 holds the presented vector in bits 5:0 and the presented level in bits 10:8. All other bits of the status word are zero.
- R9: After reset, all flags, enables, levels and the control word are 0, and the outputs are 0. The block is therefore in single-vector mode.
- R10: The presented outputs are registered. A change in flag, enable, level or control state reaches the outputs one clock edge later, so a request sampled at edge N is presented after edge N+1.
- R11: Enable bits are read/write at address 0x08+k, where bit b is source 32k+b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC (96) | Request lines, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| cpu_vec | output | 6 | Presented vector number |
| cpu_pri | output | 3 | Presented priority level |
| cpu_srs | output | SRS_W (4) | Presented shadow register set number |

## Verification
A flag stuck high or dropped shows up on cpu_vec and cpu_pri after one more edge, and the flag word read reveals it at once. A wrong vector fold or a wrong tie-break swaps the winning vector on the next presented value, as soon as two sources of different vectors are pending together. A wrong mode bit or set selection is visible in cpu_srs in the same cycle the winner appears. The outputs are compared against a reference after every edge, so any of these faults is caught within two cycles of the stimulus that exposes it.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int REG_W   = 32;
   localparam int ADDR_W  = 8;
   localparam int VEC_W   = 6;
   localparam int PRI_W   = 3;
   localparam int PRI_FLD = 4;   // nibble per vector in a level word
   localparam int MAX_FLAG_WORDS = 8;
   localparam int MAX_PRI_WORDS  = 16;

   localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h20;
   localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h21;

   typedef logic [PRI_W-1:0] pri_t;
   typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 96
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic [NUM_SRC-1:0] clr_mask,
   input  logic [NUM_SRC-1:0] en_we,
   input  logic [NUM_SRC-1:0] en_d,
   output logic [NUM_SRC-1:0] flag_q,
   output logic [NUM_SRC-1:0] en_q,
   output logic [NUM_SRC-1:0] gated
);
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[s] <= 1'b0;
            en_q[s]   <= 1'b0;
         end else begin
            flag_q[s] <= (flag_q[s] & ~clr_mask[s]) | irq_req[s];
            if (en_we[s]) en_q[s] <= en_d[s];
         end
      end
   end

   assign gated = flag_q & en_q;

   p_req_sets_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q & $past(irq_req)) == $past(irq_req)));

   p_clear_only_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((~flag_q & $past(flag_q) & ~$past(clr_mask)) == '0));
endmodule

// File: rtl/intc_vec_merge.sv
module intc_vec_merge
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 96,
   parameter int NUM_VEC = 64
) (
   input  logic [NUM_SRC-1:0] gated,
   output logic [NUM_VEC-1:0] vec_pend
);
   always_comb begin
      vec_pend = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         vec_pend[s % NUM_VEC] = vec_pend[s % NUM_VEC] | gated[s];
      end
   end
endmodule

// File: rtl/intc_pri_store.sv
module intc_pri_store
   import intc_pkg::*;
#(
   parameter int NUM_VEC = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_VEC-1:0]           pri_we,
   input  logic [NUM_VEC-1:0][PRI_W-1:0] pri_d,
   output logic [NUM_VEC-1:0][PRI_W-1:0] pri_q
);
   for (genvar v = 0; v < NUM_VEC; v++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        pri_q[v] <= '0;
         else if (pri_we[v]) pri_q[v] <= pri_d[v];
      end
   end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
   import intc_pkg::*;
#(
   parameter int NUM_VEC = 64,
   parameter int SRS_W   = 4,
   parameter int DED_SRS = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_VEC-1:0]            vec_pend,
   input  logic [NUM_VEC-1:0][PRI_W-1:0] pri_q,
   input  logic                          mode_multi,
   input  logic [SRS_W-1:0]              single_srs,
   output vec_t                          out_vec,
   output pri_t                          out_pri,
   output logic [SRS_W-1:0]              out_srs
);
   localparam logic [SRS_W-1:0] DED = SRS_W'(DED_SRS);

   vec_t             best_v;
   pri_t             best_p;
   logic [SRS_W-1:0] srs_d;

   // descending scan with >= leaves the lowest index on ties
   always_comb begin
      best_v = '0;
      best_p = '0;
      for (int v = NUM_VEC - 1; v >= 0; v--) begin
         if (vec_pend[v] && (pri_q[v] != '0) && (pri_q[v] >= best_p)) begin
            best_p = pri_q[v];
            best_v = VEC_W'(v);
         end
      end
   end

   always_comb begin
      if (best_p == '0)       srs_d = '0;
      else if (mode_multi)    srs_d = (best_p == 3'd7) ? DED : '0;
      else                    srs_d = single_srs;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vec <= '0;
         out_pri <= '0;
         out_srs <= '0;
      end else begin
         out_vec <= best_v;
         out_pri <= best_p;
         out_srs <= srs_d;
      end
   end

   p_idle_zero_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_pri == '0) |-> ((out_vec == '0) && (out_srs == '0)));

   p_ded_set_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      mode_multi |=> ((out_pri != 3'd7) || (out_srs == DED)));
endmodule

// File: rtl/intc_vpic.sv
module intc_vpic
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 96,
   parameter int NUM_VEC = 64,
   parameter int SRS_W   = 4,
   parameter int DED_SRS = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               reg_wr,
   input  logic [7:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic [5:0]         cpu_vec,
   output logic [2:0]         cpu_pri,
   output logic [SRS_W-1:0]   cpu_srs
);
   localparam int FLAG_WORDS = (NUM_SRC + REG_W - 1) / REG_W;
   localparam int VEC_PER_W  = REG_W / PRI_FLD;
   localparam int PRI_WORDS  = (NUM_VEC + VEC_PER_W - 1) / VEC_PER_W;

   if (NUM_VEC < 1 || NUM_VEC > (1 << VEC_W)) begin : g_bad_vec
      $error("NUM_VEC out of range");
   end
   if (NUM_SRC < 1 || FLAG_WORDS > MAX_FLAG_WORDS) begin : g_bad_src
      $error("NUM_SRC out of range");
   end
   if (PRI_WORDS > MAX_PRI_WORDS) begin : g_bad_pri
      $error("too many level words");
   end
   if (SRS_W < 1 || SRS_W > 4 || DED_SRS >= (1 << SRS_W)) begin : g_bad_srs
      $error("shadow set width or dedicated set out of range");
   end

   logic flag_hit, ena_hit, pri_hit, ctrl_hit;
   assign flag_hit = (reg_addr[7:3] == 5'd0);
   assign ena_hit  = (reg_addr[7:3] == 5'd1);
   assign pri_hit  = (reg_addr[7:4] == 4'd1);
   assign ctrl_hit = (reg_addr == CTRL_ADDR);

   logic [NUM_SRC-1:0] clr_mask, en_we, en_d, flag_q, en_q, gated;
   logic [NUM_VEC-1:0] vec_pend, pri_we;
   logic [NUM_VEC-1:0][PRI_W-1:0] pri_d, pri_q;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_dec
      localparam int WI = s / REG_W;
      localparam int BI = s % REG_W;
      assign clr_mask[s] = reg_wr && flag_hit && (int'(reg_addr[2:0]) == WI) && reg_wdata[BI];
      assign en_we[s]    = reg_wr && ena_hit && (int'(reg_addr[2:0]) == WI);
      assign en_d[s]     = reg_wdata[BI];
   end

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec_dec
      localparam int WI = v / VEC_PER_W;
      localparam int LO = (v % VEC_PER_W) * PRI_FLD;
      assign pri_we[v] = reg_wr && pri_hit && (int'(reg_addr[3:0]) == WI);
      assign pri_d[v]  = reg_wdata[LO +: PRI_W];
   end

   logic             mode_multi;
   logic [SRS_W-1:0] single_srs;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_multi <= 1'b0;
         single_srs <= '0;
      end else if (reg_wr && ctrl_hit) begin
         mode_multi <= reg_wdata[0];
         single_srs <= reg_wdata[8 +: SRS_W];
      end
   end

   intc_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .clr_mask(clr_mask),
      .en_we(en_we), .en_d(en_d), .flag_q(flag_q), .en_q(en_q), .gated(gated));

   intc_vec_merge #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC)) u_merge (
      .gated(gated), .vec_pend(vec_pend));

   intc_pri_store #(.NUM_VEC(NUM_VEC)) u_lvl (
      .clk(clk), .rst_n(rst_n), .pri_we(pri_we), .pri_d(pri_d), .pri_q(pri_q));

   intc_arbiter #(.NUM_VEC(NUM_VEC), .SRS_W(SRS_W), .DED_SRS(DED_SRS)) u_arb (
      .clk(clk), .rst_n(rst_n), .vec_pend(vec_pend), .pri_q(pri_q),
      .mode_multi(mode_multi), .single_srs(single_srs),
      .out_vec(cpu_vec), .out_pri(cpu_pri), .out_srs(cpu_srs));

   // read path
   logic [MAX_FLAG_WORDS*REG_W-1:0] flag_pad, en_pad;
   logic [MAX_PRI_WORDS*REG_W-1:0]  pri_pad;
   always_comb begin
      flag_pad = '0;
      en_pad   = '0;
      pri_pad  = '0;
      flag_pad[NUM_SRC-1:0] = flag_q;
      en_pad[NUM_SRC-1:0]   = en_q;
      for (int v = 0; v < NUM_VEC; v++) pri_pad[v*PRI_FLD +: PRI_W] = pri_q[v];
   end

   always_comb begin
      reg_rdata = '0;
      if (flag_hit && int'(reg_addr[2:0]) < FLAG_WORDS)
         reg_rdata = flag_pad[reg_addr[2:0]*REG_W +: REG_W];
      else if (ena_hit && int'(reg_addr[2:0]) < FLAG_WORDS)
         reg_rdata = en_pad[reg_addr[2:0]*REG_W +: REG_W];
      else if (pri_hit && int'(reg_addr[3:0]) < PRI_WORDS)
         reg_rdata = pri_pad[reg_addr[3:0]*REG_W +: REG_W];
      else if (ctrl_hit) begin
         reg_rdata[0]          = mode_multi;
         reg_rdata[8 +: SRS_W] = single_srs;
      end else if (reg_addr == STAT_ADDR) begin
         reg_rdata[5:0]  = cpu_vec;
         reg_rdata[10:8] = cpu_pri;
      end
   end

   p_no_pend_idle_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (gated == '0) |=> (cpu_pri == '0));
endmodule

// File: tb/intc_vpic_test.sv
module intc_vpic_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [95:0] irq_req = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [5:0]  cpu_vec;
   logic [2:0]  cpu_pri;
   logic [3:0]  cpu_srs;

   always #5 clk = ~clk;

   intc_vpic uut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_vec(cpu_vec), .cpu_pri(cpu_pri), .cpu_srs(cpu_srs));

   bit [95:0] mflag, men;
   bit [2:0]  mpri [64];
   bit        mmode;
   bit [3:0]  msset;
   bit [5:0]  lv;
   bit [2:0]  lp;
   int        nchk = 0, nfail = 0;
   string     tag = "R9";
   bit        done = 0;

   task automatic chk(string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // expected presentation from model state (R3 R4 R5 R6 R7)
   function automatic void arb(output bit [5:0] v, output bit [2:0] p, output bit [3:0] s);
      v = 0; p = 0; s = 0;
      for (int i = 63; i >= 0; i--) begin
         bit pend = 0;
         for (int j = 0; j < 96; j++) if (j % 64 == i && mflag[j] && men[j]) pend = 1;
         if (pend && mpri[i] != 0 && mpri[i] >= p) begin p = mpri[i]; v = 6'(i); end
      end
      if (p != 0) s = mmode ? ((p == 7) ? 4'd1 : 4'd0) : msset;
   endfunction

   task automatic cycle(input bit [95:0] req, input bit wr, input bit [7:0] a, input bit [31:0] d);
      bit [5:0] ev; bit [2:0] ep; bit [3:0] es;
      bit [95:0] clr = '0;
      irq_req = req; reg_wr = wr; reg_addr = a; reg_wdata = d;
      arb(ev, ep, es);
      if (wr) begin
         if (a < 8'h03) clr[a*32 +: 32] = d;
         else if (a >= 8'h08 && a < 8'h0B) men[(a-8)*32 +: 32] = d;
         else if (a >= 8'h10 && a < 8'h18)
            for (int i = 0; i < 8; i++) mpri[(a-8'h10)*8 + i] = d[i*4 +: 3];
         else if (a == 8'h20) begin mmode = d[0]; msset = d[11:8]; end
      end
      mflag = (mflag & ~clr) | req;
      @(posedge clk);
      @(negedge clk);
      irq_req = '0; reg_wr = 1'b0;
      chk("cpu_vec", cpu_vec, ev);
      chk("cpu_pri", cpu_pri, ep);
      chk("cpu_srs", cpu_srs, es);
      lv = ev; lp = ep;
   endtask

   task automatic rd(input bit [7:0] a, input bit [31:0] exp, string what);
      reg_addr = a;
      #1;
      chk(what, reg_rdata, exp);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cycle('0, 0, 8'h00, 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      tag = "R9";
      chk("cpu_vec", cpu_vec, 0); chk("cpu_pri", cpu_pri, 0); chk("cpu_srs", cpu_srs, 0);
      rd(8'h20, 0, "ctrl"); rd(8'h00, 0, "flag0"); rd(8'h10, 0, "lvl0");
      tag = "R8"; rd(8'h21, 0, "status");

      // R1 / R10 sticky flag and one-edge latency
      tag = "R11";
      cycle('0, 1, 8'h10, 32'h0030_0000);      // vector 5 level 3
      cycle('0, 1, 8'h08, 32'h0000_0020);      // enable source 5
      rd(8'h08, 32'h20, "enable0");
      tag = "R10";
      cycle(96'h20, 0, 0, 0);                  // outputs still idle after sampling edge
      tag = "R1";
      idle(3);
      chk("cpu_vec", cpu_vec, 5);
      rd(8'h00, 32'h20, "flag0 sticky");
      tag = "R8"; rd(8'h21, 32'h0000_0305, "status");

      // R2 clear and set-wins
      tag = "R2";
      cycle('0, 1, 8'h00, 32'h20);
      idle(1);
      rd(8'h00, 0, "flag0 cleared");
      cycle(96'h20, 1, 8'h00, 32'h20);
      rd(8'h00, 32'h20, "flag0 set wins");
      idle(1);

      // R3 enable gating
      tag = "R3";
      cycle('0, 1, 8'h08, 0);
      idle(1);
      chk("cpu_pri gated", cpu_pri, 0);
      rd(8'h00, 32'h20, "flag kept");

      // R4 folding: source 70 -> vector 6
      tag = "R4";
      cycle('0, 1, 8'h10, 32'h0200_0000);      // vector 6 level 2
      cycle('0, 1, 8'h0A, 32'h40);             // enable source 70
      cycle(96'h1 << 70, 0, 0, 0);
      idle(1);
      chk("cpu_vec fold", cpu_vec, 6);

      // R5 level 0 never wins
      tag = "R5";
      cycle('0, 1, 8'h10, 0);
      idle(1);
      chk("cpu_pri zero", cpu_pri, 0);
      chk("cpu_vec zero", cpu_vec, 0);

      // R6 tie and order: vectors 9 and 12
      tag = "R6";
      cycle('0, 1, 8'h08, 32'h1200);
      cycle('0, 1, 8'h11, 32'h0004_0040);      // v9 = 4, v12 = 4
      cycle(96'h1200, 0, 0, 0);
      idle(1);
      chk("cpu_vec tie", cpu_vec, 9);
      cycle('0, 1, 8'h11, 32'h0005_0040);      // v12 = 5
      idle(1);
      chk("cpu_vec higher", cpu_vec, 12);

      // R7 shadow sets
      tag = "R7";
      cycle('0, 1, 8'h11, 32'h0007_0040);      // v12 = 7
      cycle('0, 1, 8'h20, 32'h1);              // multi
      idle(1);
      chk("cpu_srs ded", cpu_srs, 1);
      cycle('0, 1, 8'h11, 32'h0005_0040);
      idle(1);
      chk("cpu_srs multi low", cpu_srs, 0);
      cycle('0, 1, 8'h20, 32'h600);            // single, set 6
      idle(1);
      chk("cpu_srs single", cpu_srs, 6);
      rd(8'h20, 32'h600, "ctrl");

      // random phase
      tag = "R6";
      for (int n = 0; n < 600; n++) begin
         bit [95:0] rq = '0;
         bit        w  = ($urandom % 3) == 0;
         bit [7:0]  a;
         bit [31:0] d  = $urandom;
         int        sel = $urandom % 10;
         if ($urandom % 3 == 0) rq[$urandom % 96] = 1'b1;
         if ($urandom % 5 == 0) rq[$urandom % 96] = 1'b1;
         if (sel < 2)      begin a = 8'($urandom % 3); d = d & $urandom & $urandom; end
         else if (sel < 5) a = 8'h08 + 8'($urandom % 3);
         else if (sel < 9) a = 8'h10 + 8'($urandom % 8);
         else              a = 8'h20;
         cycle(rq, w, a, d);
         tag = "R8"; rd(8'h21, {21'b0, lp, 2'b0, lv}, "status");
         tag = "R1";
         begin
            int k = $urandom % 3;
            rd(8'(k), mflag[k*32 +: 32], "flag word");
         end
         tag = "R6";
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule